// File: doc/BRIEF.md
# Multi-Lane SIMD Register Controller

This block runs one broadcast ALU instruction across a set of replicated 32-bit lanes. Each lane owns a small private register file. A lane-enable register chooses which lanes take part: when an instruction is issued, every enabled lane reads its own two source registers, computes either a full 32-bit add or a partitioned add, and writes its own destination register. The partitioned add uses one shared partition mask for all lanes. A set mask bit stops the carry from entering that bit position, which splits the word into independent fields, for example two packed 5-6-5 colour pixels.

The lane-enable register is not a plain store. Only the bits that belong to real lanes hold a value. A write whose implemented bits are all zero starts a cleanup: every register in lanes 1 and up is cleared, the save-needed flags of those lanes are cleared, and the enable register is left holding 1, so lane 0 keeps running. Each lane from 1 upward has a save-needed (dirty) flag. The flag is set whenever a register write lands in that lane, so context-switch code knows which lanes to save. A separate writeback port places values into any lane's registers, and a read port returns any lane's register.

Top module: `simd_lane_ctrl`

## Requirements
- R1: After synchronous reset the enable register reads 1, every register of every lane reads zero and all dirty flags are 0.
- R2: A write to the enable register whose low NLANES bits are not all zero stores those bits. Bits NLANES and above always read as zero.
- R3: A write whose low NLANES bits are all zero makes the enable register read exactly 1 from the next cycle on. From that cycle all registers of lanes 1 and up read zero, and lane 0's registers keep their values.
- R4: That same wipe write clears all dirty flags. It wins over any op or writeback landing in lanes 1 and up in the same cycle, so those registers read zero and their flags read 0 afterwards.
- R5: With op_kind = 0, each lane whose enable bit is set writes rd = rs1 + rs2 modulo 2^32, using its own registers. The result is readable in the cycle after issue.
- R6: With op_kind = 1, each enabled lane writes a partitioned sum. Bit i of part_mask set to 1 blocks the carry into bit i, so the word is split into fields that add independently, each modulo its own width.
- R7: An op leaves the registers and the dirty flag of every lane whose enable bit is 0 unchanged.
- R8: Register 0 of every lane reads zero. A write to address 0 from an op or from the writeback port is ignored and does not set a dirty flag.
- R9: lane_dirty bit L, for L from 1 up, becomes 1 in the cycle after a write lands in a nonzero register of lane L. lane_dirty bit 0 is always 0.
- R10: The writeback port writes ld_data to register ld_addr of lane ld_lane whether or not that lane is enabled. If an op writes the same lane in the same cycle, the op result is stored and the writeback is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the lane-enable register |
| en_wdata | input | 32 | Value written to the lane-enable register |
| en_rdata | output | 32 | Current lane-enable value |
| part_mask | input | 32 | Shared carry-block mask for the partitioned add |
| op_valid | input | 1 | Issue one broadcast instruction this cycle |
| op_kind | input | 1 | 0 = full add, 1 = partitioned add |
| op_rs1 | input | log2(NREGS) | First source register |
| op_rs2 | input | log2(NREGS) | Second source register |
| op_rd | input | log2(NREGS) | Destination register |
| ld_valid | input | 1 | Writeback port strobe |
| ld_lane | input | log2(NLANES) | Writeback target lane |
| ld_addr | input | log2(NREGS) | Writeback target register |
| ld_data | input | 32 | Writeback data |
| rd_lane | input | log2(NLANES) | Read port lane select |
| rd_addr | input | log2(NREGS) | Read port register select |
| rd_data | output | 32 | Register value, combinational |
| lane_dirty | output | NLANES | Save-needed flag per lane |

## Verification
The full add is tried with different operands in each lane, including one lane whose sum wraps past 2^32, so a design that shares operands between lanes or keeps the carry-out is caught. The partitioned add is run with a 5-6-5 pixel-pair mask on operands whose fields overflow, which separates field-local carries from a plain add. It is also run with an all-ones mask, where the result must equal the XOR of the operands. Enable patterns 0xF, 0x5 and 1 separate enabled from disabled lanes. Wipe writes are tried with the value zero, with a value that has only unimplemented bits set, and together with an op in the same cycle, to check that the wipe wins.

// File: rtl/simd_lane_pkg.sv
`timescale 1ns/1ps
package simd_lane_pkg;

    localparam int XLEN = 32;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic {
        OP_ADD  = 1'b0,
        OP_PADD = 1'b1
    } op_kind_e;

    // one lane's write request after arbitration
    typedef struct packed {
        logic  we;
        word_t data;
    } lane_wr_t;

    // add with carry blocked at every position whose mask bit is set
    function automatic word_t packed_add(word_t a, word_t b, word_t mask);
        logic  c;
        word_t s;
        c = 1'b0;
        s = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (mask[i]) c = 1'b0;
            s[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return s;
    endfunction

    function automatic word_t impl_mask(int n);
        word_t m;
        m = '0;
        for (int i = 0; i < XLEN; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/lane_enable_ctl.sv
`timescale 1ns/1ps
module lane_enable_ctl
    import simd_lane_pkg::*;
#(
    parameter int NLANES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  word_t             wdata,
    output logic [NLANES-1:0] en_q,
    output logic              wipe,
    output word_t             rdata
);
    localparam word_t IMPL = impl_mask(NLANES);
    localparam logic [NLANES-1:0] ONLY_LANE0 = NLANES'(1);

    // a write that would switch every lane off becomes the cleanup request
    assign wipe = wr && ((wdata & IMPL) == '0);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= ONLY_LANE0;
        else if (wr)
            en_q <= wipe ? ONLY_LANE0 : wdata[NLANES-1:0];
    end

    always_comb begin
        rdata = '0;
        rdata[NLANES-1:0] = en_q;
    end
endmodule

// File: rtl/lane_alu.sv
`timescale 1ns/1ps
module lane_alu
    import simd_lane_pkg::*;
(
    input  op_kind_e kind,
    input  word_t    a,
    input  word_t    b,
    input  word_t    mask,
    output word_t    y
);
    always_comb begin
        unique case (kind)
            OP_ADD:  y = a + b;
            OP_PADD: y = packed_add(a, b, mask);
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/lane_regfile.sv
`timescale 1ns/1ps
module lane_regfile
    import simd_lane_pkg::*;
#(
    parameter int NREGS     = 8,
    parameter bit CLEARABLE = 1'b1,
    localparam int AW       = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wipe,
    input  lane_wr_t      wr,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output word_t         rd1,
    output word_t         rd2,
    output word_t         rd3,
    output logic          dirty
);
    word_t mem [NREGS];

    logic clr;
    assign clr = CLEARABLE && wipe;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
            dirty <= 1'b0;
        end else if (wr.we && (waddr != '0)) begin
            mem[waddr] <= wr.data;
            dirty      <= CLEARABLE;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
    assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
    assign rd3 = (ra3 == '0) ? '0 : mem[ra3];
endmodule

// File: rtl/simd_lane_ctrl.sv
`timescale 1ns/1ps
module simd_lane_ctrl
    import simd_lane_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int NREGS  = 8,
    localparam int AW    = $clog2(NREGS),
    localparam int LW    = $clog2(NLANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic [31:0]       en_wdata,
    output logic [31:0]       en_rdata,
    input  logic [31:0]       part_mask,
    input  logic              op_valid,
    input  logic              op_kind,
    input  logic [AW-1:0]     op_rs1,
    input  logic [AW-1:0]     op_rs2,
    input  logic [AW-1:0]     op_rd,
    input  logic              ld_valid,
    input  logic [LW-1:0]     ld_lane,
    input  logic [AW-1:0]     ld_addr,
    input  logic [31:0]       ld_data,
    input  logic [LW-1:0]     rd_lane,
    input  logic [AW-1:0]     rd_addr,
    output logic [31:0]       rd_data,
    output logic [NLANES-1:0] lane_dirty
);
    logic [NLANES-1:0] lane_en;
    logic              wipe;
    word_t             peek [NLANES];

    lane_enable_ctl #(.NLANES(NLANES)) u_en (
        .clk   (clk),
        .rst   (rst),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en_q  (lane_en),
        .wipe  (wipe),
        .rdata (en_rdata)
    );

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        word_t         src_a, src_b, alu_y;
        logic          op_hit, ld_hit;
        lane_wr_t      wr;
        logic [AW-1:0] waddr;

        lane_alu u_alu (
            .kind (op_kind_e'(op_kind)),
            .a    (src_a),
            .b    (src_b),
            .mask (part_mask),
            .y    (alu_y)
        );

        // op writeback wins over the writeback port inside one lane
        assign op_hit  = op_valid && lane_en[l];
        assign ld_hit  = ld_valid && (ld_lane == LW'(l));
        assign wr.we   = op_hit || ld_hit;
        assign wr.data = op_hit ? alu_y : ld_data;
        assign waddr   = op_hit ? op_rd : ld_addr;

        lane_regfile #(.NREGS(NREGS), .CLEARABLE(l != 0)) u_rf (
            .clk   (clk),
            .rst   (rst),
            .wipe  (wipe),
            .wr    (wr),
            .waddr (waddr),
            .ra1   (op_rs1),
            .ra2   (op_rs2),
            .ra3   (rd_addr),
            .rd1   (src_a),
            .rd2   (src_b),
            .rd3   (peek[l]),
            .dirty (lane_dirty[l])
        );
    end

    assign rd_data = peek[rd_lane];
endmodule

// File: rtl/simd_lane_ctrl_chk.sv
`timescale 1ns/1ps
module simd_lane_ctrl_chk #(
    parameter int NLANES = 4,
    parameter int NREGS  = 8,
    localparam int AW    = $clog2(NREGS),
    localparam int LW    = $clog2(NLANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              en_wr,
    input logic [31:0]       en_wdata,
    input logic [31:0]       en_rdata,
    input logic              ld_valid,
    input logic [LW-1:0]     ld_lane,
    input logic [AW-1:0]     rd_addr,
    input logic [31:0]       rd_data,
    input logic [NLANES-1:0] lane_dirty
);
    localparam logic [31:0] IMPL = simd_lane_pkg::impl_mask(NLANES);

    logic zero_wr;
    assign zero_wr = en_wr && ((en_wdata & IMPL) == 32'd0);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_rdata == 32'd1) && (lane_dirty == '0));

    a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
        ((en_rdata & ~IMPL) == 32'd0) && (en_rdata != 32'd0));

    a_r2_plain_store: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !zero_wr) |=> en_rdata == ($past(en_wdata) & IMPL));

    a_r3_wipe_reads_one: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> en_rdata == 32'd1);

    a_r4_wipe_clears_dirty: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> lane_dirty == '0);

    a_r8_reg0_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0) |-> rd_data == 32'd0);

    a_r9_lane0_clean: assert property (@(posedge clk) disable iff (rst)
        !lane_dirty[0]);

    for (genvar l = 1; l < NLANES; l++) begin : g_idle
        // R7: a disabled lane with no writeback aimed at it stays clean
        a_r7_idle_lane_clean: assert property (@(posedge clk) disable iff (rst)
            (!en_rdata[l] && !(ld_valid && ld_lane == LW'(l)) && !lane_dirty[l])
            |=> !lane_dirty[l]);
    end
endmodule

bind simd_lane_ctrl simd_lane_ctrl_chk #(.NLANES(NLANES), .NREGS(NREGS)) u_chk (.*);

// File: tb/simd_lane_ctrl_test.sv
`timescale 1ns/1ps
module simd_lane_ctrl_test;
    localparam int NL = 4;
    localparam int NR = 8;
    localparam int AW = 3;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_wr = 1'b0;
    logic [31:0]   en_wdata = '0;
    logic [31:0]   en_rdata;
    logic [31:0]   part_mask = '0;
    logic          op_valid = 1'b0;
    logic          op_kind = 1'b0;
    logic [AW-1:0] op_rs1 = '0, op_rs2 = '0, op_rd = '0;
    logic          ld_valid = 1'b0;
    logic [LW-1:0] ld_lane = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [LW-1:0] rd_lane = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NL-1:0] lane_dirty;

    simd_lane_ctrl #(.NLANES(NL), .NREGS(NR)) uut (.*);

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mdl [NL][NR];
    logic [NL-1:0] mdl_en;
    logic [NL-1:0] mdl_dirty;

    typedef struct {
        int          lane;
        int          addr;
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t q[$];
    bit busy = 0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // field-by-field sum: a new field starts at every set mask bit
    function automatic logic [31:0] seg_add(logic [31:0] a, logic [31:0] b, logic [31:0] m);
        logic [63:0] res, fa, fb, fm;
        int lo;
        res = '0;
        lo = 0;
        for (int i = 1; i <= 32; i++) begin
            if (i == 32 || m[i]) begin
                fm  = (64'd1 << (i - lo)) - 64'd1;
                fa  = ({32'd0, a} >> lo) & fm;
                fb  = ({32'd0, b} >> lo) & fm;
                res = res | (((fa + fb) & fm) << lo);
                lo  = i;
            end
        end
        return res[31:0];
    endfunction

    task automatic expect_reg(int l, int a, string tag);
        item_t it;
        it.lane = l; it.addr = a; it.val = mdl[l][a]; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic flush();
        wait (q.size() == 0 && !busy);
        #0.1;
    endtask

    // monitor: pops expected items and compares them with the read port
    initial begin
        forever begin
            wait (q.size() != 0);
            busy = 1;
            begin
                item_t it;
                it = q.pop_front();
                rd_lane = LW'(it.lane);
                rd_addr = AW'(it.addr);
                #0.2;
                check(rd_data === it.val, $sformatf("%s lane%0d r%0d", it.tag, it.lane, it.addr),
                      rd_data, it.val);
            end
            busy = 0;
        end
    end

    // one clock of stimulus; the model follows the requirements
    task automatic step(bit do_en, logic [31:0] env, bit do_op, bit kind,
                        int s1, int s2, int d, bit do_ld, int ll, int la,
                        logic [31:0] ldv);
        logic [31:0] res [NL];
        bit wipe_now;
        en_wr = do_en; en_wdata = env;
        op_valid = do_op; op_kind = kind;
        op_rs1 = AW'(s1); op_rs2 = AW'(s2); op_rd = AW'(d);
        ld_valid = do_ld; ld_lane = LW'(ll); ld_addr = AW'(la); ld_data = ldv;
        @(posedge clk);
        #1;
        en_wr = 0; op_valid = 0; ld_valid = 0;
        wipe_now = do_en && (env[NL-1:0] == '0);
        for (int l = 0; l < NL; l++)
            res[l] = kind ? seg_add(mdl[l][s1], mdl[l][s2], part_mask)
                          : mdl[l][s1] + mdl[l][s2];
        for (int l = 0; l < NL; l++) begin
            if (do_op && mdl_en[l]) begin
                if (d != 0) begin
                    mdl[l][d] = res[l];
                    if (l != 0) mdl_dirty[l] = 1'b1;
                end
            end else if (do_ld && ll == l && la != 0) begin
                mdl[l][la] = ldv;
                if (l != 0) mdl_dirty[l] = 1'b1;
            end
        end
        if (wipe_now) begin
            for (int l = 1; l < NL; l++)
                for (int r = 0; r < NR; r++) mdl[l][r] = '0;
            mdl_dirty = '0;
            mdl_en = NL'(1);
        end else if (do_en) begin
            mdl_en = env[NL-1:0];
        end
    endtask

    task automatic en_write(logic [31:0] v);
        step(1, v, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic op(bit kind, int s1, int s2, int d);
        step(0, 0, 1, kind, s1, s2, d, 0, 0, 0, 0);
    endtask
    task automatic load(int l, int a, logic [31:0] v);
        step(0, 0, 0, 0, 0, 0, 0, 1, l, a, v);
    endtask

    task automatic expect_all(int a, string tag);
        for (int l = 0; l < NL; l++) expect_reg(l, a, tag);
        flush();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++)
            for (int r = 0; r < NR; r++) mdl[l][r] = '0;
        mdl_en = NL'(1);
        mdl_dirty = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        check(en_rdata == 32'd1, "R1 enable after reset", en_rdata, 32'd1);
        check(lane_dirty == '0, "R1 dirty after reset", 32'(lane_dirty), 0);
        expect_all(1, "R1");
        expect_all(7, "R1");

        // R2: only implemented bits are stored
        en_write(32'hFFFF_FFFF);
        check(en_rdata == 32'h0000_000F, "R2 all-ones write", en_rdata, 32'hF);

        // R10 / R9: writeback port fills every lane
        for (int l = 0; l < NL; l++) begin
            load(l, 1, 32'h0F0F_0F0F * (l + 1) + 32'h1F);
            load(l, 2, 32'h1234_5678 ^ (32'h0101_0101 << l));
        end
        load(3, 1, 32'hFFFF_FFFF);
        load(3, 2, 32'h0000_0002);
        check(lane_dirty == 4'b1110, "R9 dirty after writes", 32'(lane_dirty), 32'hE);
        expect_all(1, "R10");
        expect_all(2, "R10");

        // R5: full add in every lane, lane 3 wraps
        op(0, 1, 2, 3);
        expect_all(3, "R5");
        check(mdl[3][3] == 32'h1, "R5 wrap sum model", mdl[3][3], 32'h1);

        // R6: partitioned add with pixel-pair mask, then all-ones mask
        part_mask = (32'd1 << 5) | (32'd1 << 11) | (32'd1 << 16) | (32'd1 << 21) | (32'd1 << 27);
        op(1, 1, 2, 4);
        expect_all(4, "R6");
        part_mask = 32'hFFFF_FFFF;
        op(1, 1, 2, 5);
        expect_all(5, "R6");
        check(mdl[2][5] == (mdl[2][1] ^ mdl[2][2]), "R6 xor identity", mdl[2][5],
              mdl[2][1] ^ mdl[2][2]);
        part_mask = '0;

        // R3 / R4: write with only unimplemented bits set acts as a wipe
        en_write(32'h0000_0030);
        check(en_rdata == 32'd1, "R3 masked-zero write", en_rdata, 32'd1);
        check(lane_dirty == '0, "R4 dirty cleared", 32'(lane_dirty), 0);
        for (int a = 1; a < 6; a++) expect_all(a, "R3");

        // R7: lanes 0 and 2 enabled only
        en_write(32'h5);
        check(en_rdata == 32'h5, "R2 partial enable", en_rdata, 32'h5);
        load(1, 1, 32'h111);
        load(2, 1, 32'h222);
        load(2, 2, 32'h20);
        op(0, 1, 2, 6);
        expect_all(6, "R7");
        check(lane_dirty == 4'b0110, "R7 dirty of disabled lane", 32'(lane_dirty), 32'h6);

        // R8: register 0 cannot be written
        en_write(32'hF);
        op(0, 1, 2, 0);
        load(3, 0, 32'h0000_0ABC);
        expect_all(0, "R8");
        check(lane_dirty == 4'b0110, "R8 dirty untouched", 32'(lane_dirty), 32'h6);

        // R4: wipe and op in the same cycle
        step(1, 32'h0, 1, 0, 1, 2, 7, 0, 0, 0, 0);
        check(en_rdata == 32'd1, "R3 zero write", en_rdata, 32'd1);
        check(lane_dirty == '0, "R4 wipe beats op", 32'(lane_dirty), 0);
        expect_all(7, "R4");
        expect_all(1, "R3");

        // R10: op wins over writeback in lane 0; disabled lane 2 takes writeback
        step(0, 0, 1, 0, 1, 2, 5, 1, 0, 5, 32'h0000_DEAD);
        expect_reg(0, 5, "R10 op wins");
        flush();
        step(0, 0, 1, 0, 1, 2, 5, 1, 2, 5, 32'h0000_BEEF);
        expect_all(5, "R10 disabled lane");
        check(lane_dirty == 4'b0100, "R9 writeback into disabled lane", 32'(lane_dirty), 32'h4);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule